// File: doc/BRIEF.md
# Interrupt Request Conditioner

This block sits between an active-low external interrupt pin and a processor core and turns the pin into a single internal request line. A configuration input chooses one of two ways of reading the pin.

In falling-edge mode, a high-to-low transition is captured and held as a pending request until the core acknowledges it. In level mode, the request simply mirrors a low level on the pin, so several open-drain sources can share the pin and any one of them holding it low keeps the request raised. The raw pin is first brought into the clock domain by a two-flop synchronizer. Edge detection and level sampling both work on the synchronized value.

Top module: `irq_conditioner`

## Requirements
- R1: The pin passes through two synchronizing flops. In level mode, a change on the pin reaches `irq_req` after the second rising clock edge that samples it, and not after the first.
- R2: With `edge_mode` = 0, `irq_req` is 1 exactly while the synchronized pin is low. Any source pulling the shared pin low keeps the request raised, and the request drops once the pin is back high.
- R3: With `edge_mode` = 0, `ack` has no effect on `irq_req`.
- R4: With `edge_mode` = 1, a falling edge sets a pending latch. A falling edge is a synchronized sample at 1 followed by a sample at 0. `irq_req` rises after the third clock edge counted from the edge that first samples the pin low.
- R5: In falling-edge mode, once set, the pending latch holds. This is true whether the pin returns high or stays low. A pin held low produces no further edge after the latch is cleared.
- R6: In falling-edge mode, `ack` high at a clock edge clears the pending latch, so `irq_req` is 0 after that edge.
- R7: In falling-edge mode, if a falling edge and `ack` fall on the same clock edge, the latch stays set.
- R8: While `edge_mode` = 0, the pending latch is held clear. Returning to falling-edge mode starts with no request pending.
- R9: While `rst_n` is low, `irq_req` is 0. This holds even with the pin low in level mode, because the synchronizer presets to the idle-high state. A request pending before reset is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Raw active-low interrupt pin, asynchronous |
| edge_mode | input | 1 | 1 = falling-edge mode, 0 = level mode |
| ack | input | 1 | One-cycle acknowledge from the core when the interrupt is honoured |
| irq_req | output | 1 | Conditioned interrupt request to the core |

## Verification
Two events can coincide at one clock edge: a newly detected falling edge setting the latch, and an acknowledge clearing it. The stimulus times a pin drop so that the synchronized falling edge lands on the same edge as an `ack` pulse. The request is required to stay high afterwards, which shows that the set takes priority. A second acknowledge, given on its own while the pin remains low, must then clear the request and not let it re-arm.

// File: rtl/irq_conditioner.sv
module irq_conditioner (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_pin_n,
  input  logic edge_mode,
  input  logic ack,
  output logic irq_req
);

  logic [1:0] sync_q;
  logic       prev_q;
  logic       pend_q;
  logic       pin_s;
  logic       fall;

  assign pin_s = sync_q[1];
  assign fall  = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], irq_pin_n};
      prev_q <= pin_s;
      if (!edge_mode)
        pend_q <= 1'b0;
      else if (fall)
        pend_q <= 1'b1;
      else if (ack)
        pend_q <= 1'b0;
    end
  end

  assign irq_req = edge_mode ? pend_q : ~pin_s;

endmodule

// File: rtl/irq_conditioner_chk.sv
module irq_conditioner_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_pin_n,
  input logic edge_mode,
  input logic ack,
  input logic irq_req
);

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_rst <= 3'd0;
    else if (since_rst != 3'd7)
      since_rst <= since_rst + 3'd1;
  end

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd2 && !edge_mode) |-> (irq_req == !$past(irq_pin_n, 2)));

  assert_edge_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && edge_mode && $past(edge_mode) && $rose(irq_req))
      |-> ($past(irq_pin_n, 4) && !$past(irq_pin_n, 3)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && edge_mode && $past(edge_mode) && $past(irq_req) && !$past(ack))
      |-> irq_req);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && edge_mode && $past(edge_mode) && $past(ack)
      && !($past(irq_pin_n, 4) && !$past(irq_pin_n, 3)))
      |-> !irq_req);

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && edge_mode && $past(edge_mode)
      && $past(irq_pin_n, 4) && !$past(irq_pin_n, 3))
      |-> irq_req);

  assert_level_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && edge_mode && !$past(edge_mode)) |-> !irq_req);

endmodule

bind irq_conditioner irq_conditioner_chk chk (
  .clk(clk),
  .rst_n(rst_n),
  .irq_pin_n(irq_pin_n),
  .edge_mode(edge_mode),
  .ack(ack),
  .irq_req(irq_req)
);

// File: tb/tb_irq_conditioner.sv
module tb_irq_conditioner;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pin_n = 1'b0;
  logic edge_mode = 1'b0;
  logic ack = 1'b0;
  logic irq_req;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_conditioner dut (
    .clk(clk),
    .rst_n(rst_n),
    .irq_pin_n(irq_pin_n),
    .edge_mode(edge_mode),
    .ack(ack),
    .irq_req(irq_req)
  );

  // fields: {pin, edge_mode, ack, expected irq_req}
  localparam int NV = 28;
  localparam logic [3:0] VEC [NV] = '{
    4'b1000, 4'b0000, 4'b0011, 4'b0011, 4'b1001, 4'b1000,
    4'b1100, 4'b1100, 4'b0100, 4'b0100, 4'b0101, 4'b1101,
    4'b1101, 4'b1110, 4'b1100, 4'b0100, 4'b0100, 4'b0111,
    4'b0101, 4'b0110, 4'b0100, 4'b1100, 4'b0100, 4'b1100,
    4'b1101, 4'b1101, 4'b1000, 4'b1100
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:                 return "R1";
      2, 4, 5:              return "R2";
      3:                    return "R3";
      11, 12, 20, 25:       return "R5";
      13, 14, 19:           return "R6";
      17, 18:               return "R7";
      26, 27:               return "R8";
      default:              return "R4";
    endcase
  endfunction

  task automatic check(string req, logic exp);
    applied++;
    if (irq_req !== exp) begin
      bad++;
      $display("FAIL %s: irq_req=%b expected %b at %0t", req, irq_req, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    // R9: level mode, pin low, held in reset
    repeat (3) @(negedge clk);
    check("R9", 1'b0);
    irq_pin_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      irq_pin_n = VEC[i][3];
      edge_mode = VEC[i][2];
      ack       = VEC[i][1];
      step();
      check(tag_of(i), VEC[i][0]);
    end

    // R4: fresh edge in edge mode, third edge latency
    irq_pin_n = 1'b0; edge_mode = 1'b1; ack = 1'b0;
    step(); check("R4", 1'b0);
    step(); check("R4", 1'b0);
    step(); check("R4", 1'b1);

    // R9: reset discards pending request
    rst_n = 1'b0;
    #1 check("R9", 1'b0);
    irq_pin_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    step(); step(); step();
    check("R9", 1'b0);

    // R3: repeated ack in level mode while pin low
    edge_mode = 1'b0; irq_pin_n = 1'b0;
    step(); step();
    ack = 1'b1;
    step(); check("R3", 1'b1);
    step(); check("R3", 1'b1);
    ack = 1'b0;
    irq_pin_n = 1'b1;
    step(); check("R1", 1'b1);
    step(); check("R1", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule